// File: doc/BRIEF.md
# Multi-op fused arithmetic unit

This functional unit evaluates one of five compound integer expressions and returns a single result. The expressions come from state-prediction and state-update arithmetic in filters: a nested multiply-accumulate, a single multiply-add, a pair of multiply-adds and a pair of multiply-subtracts, and a difference of products divided by a fifth operand. A three-bit opcode picks the expression. Operands reach the unit over three lanes, which is the read-port budget of the register file that feeds it.

The time shape is rigid. An operation with three sources presents them all in its issue cycle. A five-source operation presents its first three sources in the issue cycle and its last two on lanes A and B in the cycle after that. Every non-dividing expression is computed at twice the data width and then truncated. The dividing expression goes through a sequential signed restoring divider. While the divider runs, the busy output stays high and the unit refuses new work.

Top module: `fused_op_unit`

## Requirements
- R1: Opcode 1 returns s1 + s2*(s3 + s4 + s5*s2), truncated to W bits.
- R2: Opcode 2 returns s1 + s2*s3 from lanes A, B and C of the issue cycle. result_valid_o is high in the first cycle after issue, and busy_o never rises.
- R3: Opcode 3 returns (s3*s4 - s1*s2) / s5 as signed two's-complement division, truncated toward zero and then to W bits.
- R4: Opcode 4 returns s1 + s2*s3 + s4*s5, truncated to W bits.
- R5: Opcode 5 returns s1 - s2*s3 - s4*s5, truncated to W bits.
- R6: For opcodes 1, 3, 4 and 5, s1, s2 and s3 are taken from lanes A, B and C in the issue cycle, and s4 and s5 from lanes A and B in the next cycle. For opcodes 1, 4 and 5, result_valid_o is high exactly 2 cycles after issue, and busy_o is high in cycle 1.
- R7: For opcode 3, result_valid_o is high exactly 2W+4 cycles after issue. busy_o is high from cycle 1 through the cycle before the result, and low when the result appears.
- R8: For opcode 3 with s5 equal to zero, the result is all ones, and div_zero_o is high for exactly the one cycle in which result_valid_o is high.
- R9: Results wrap modulo 2^W. Operands are two's-complement values and may be negative.
- R10: An issue that arrives while busy_o is high, including one in the cycle that carries s4 and s5, is ignored. The running operation's result and timing are unchanged, and the ignored issue produces no result.
- R11: An issue with opcode 0, 6 or 7 is ignored: no result_valid_o, busy_o stays low, and result_o keeps its value.
- R12: After reset, result_o is zero and result_valid_o, busy_o and div_zero_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Start an operation this cycle |
| opcode_i | input | 3 | Expression select, 1 to 5 |
| lane_a_i | input | W | s1 at issue, s4 one cycle later |
| lane_b_i | input | W | s2 at issue, s5 one cycle later |
| lane_c_i | input | W | s3 at issue |
| result_o | output | W | Last result, held between results |
| result_valid_o | output | 1 | result_o is new this cycle |
| busy_o | output | 1 | Unit is occupied and refuses issues |
| div_zero_o | output | 1 | The current result came from a zero divisor |

## Verification
The assertions check the following on every cycle:
- a multiply-add issue produces a result in the next cycle;
- a five-source issue raises busy without producing a result;
- a result never appears while the unit is busy;
- the divide-by-zero flag only appears alongside an all-ones valid result;
- the divider is never restarted while it is running.

Only the bench scenarios can show the rest:
- the arithmetic of each expression with negative, wrapping and extreme operands;
- truncation toward zero;
- the exact divide latency;
- that issues arriving while busy, or carrying unused opcodes, leave the result unchanged.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

    localparam logic [2:0] OPC_POLY  = 3'd1;
    localparam logic [2:0] OPC_MAC   = 3'd2;
    localparam logic [2:0] OPC_QUOT  = 3'd3;
    localparam logic [2:0] OPC_SUM2  = 3'd4;
    localparam logic [2:0] OPC_DIFF2 = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_DIVIDE = 2'd2
    } fuse_state_t;

endpackage

// File: rtl/fuse_expr.sv
module fuse_expr #(
    parameter int W  = 16,
    parameter int NW = 2 * W + 1
) (
    input  logic [2:0]    op_i,
    input  logic [W-1:0]  s1_i,
    input  logic [W-1:0]  s2_i,
    input  logic [W-1:0]  s3_i,
    input  logic [W-1:0]  s4_i,
    input  logic [W-1:0]  s5_i,
    output logic [W-1:0]  res_o,
    output logic [NW-1:0] num_o
);
    import fuse_pkg::*;

    localparam int W2 = 2 * W;

    logic signed [W2-1:0] e1, e2, e3, e4, e5;
    logic signed [W2-1:0] inner, wide;
    logic signed [NW-1:0] n1, n2, n3, n4, num;

    always_comb begin
        e1 = W2'($signed(s1_i));
        e2 = W2'($signed(s2_i));
        e3 = W2'($signed(s3_i));
        e4 = W2'($signed(s4_i));
        e5 = W2'($signed(s5_i));
        n1 = NW'($signed(s1_i));
        n2 = NW'($signed(s2_i));
        n3 = NW'($signed(s3_i));
        n4 = NW'($signed(s4_i));
        inner = e3 + e4 + e5 * e2;
        num   = n3 * n4 - n1 * n2;
        case (op_i)
            OPC_POLY:  wide = e1 + e2 * inner;
            OPC_MAC:   wide = e1 + e2 * e3;
            OPC_SUM2:  wide = e1 + e2 * e3 + e4 * e5;
            OPC_DIFF2: wide = e1 - e2 * e3 - e4 * e5;
            default:   wide = '0;
        endcase
        res_o = wide[W-1:0];
        num_o = num;
    end

endmodule

// File: rtl/fuse_divider.sv
module fuse_divider #(
    parameter int NW = 33,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [NW-1:0] num_i,
    input  logic [DW-1:0] den_i,
    output logic [NW-1:0] quo_o,
    output logic          active_o,
    output logic          done_o
);
    localparam int CW = $clog2(NW);

    typedef struct packed {
        logic [DW-1:0] rem;
        logic [NW-1:0] quo;
        logic [DW-1:0] den;
        logic [CW-1:0] cnt;
        logic          act;
        logic          done;
    } div_t;

    div_t q, d;
    logic [DW:0]   shifted;
    logic [DW+1:0] trial;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        shifted = {q.rem, q.quo[NW-1]};
        trial   = {1'b0, shifted} - {2'b00, q.den};
        if (start_i) begin
            d.rem = '0;
            d.quo = num_i;
            d.den = den_i;
            d.cnt = '0;
            d.act = 1'b1;
        end else if (q.act) begin
            if (!trial[DW+1]) begin
                d.rem = trial[DW-1:0];
                d.quo = {q.quo[NW-2:0], 1'b1};
            end else begin
                d.rem = shifted[DW-1:0];
                d.quo = {q.quo[NW-2:0], 1'b0};
            end
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == CW'(NW - 1)) begin
                d.act  = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign quo_o    = q.quo;
    assign active_o = q.act;
    assign done_o   = q.done;

    // R10: a second issue never restarts a divide in flight
    assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !q.act);

    // R7: completion follows a running divide
    assert_done_after_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> $past(q.act));

endmodule

// File: rtl/fused_op_unit.sv
module fused_op_unit #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         issue_i,
    input  logic [2:0]   opcode_i,
    input  logic [W-1:0] lane_a_i,
    input  logic [W-1:0] lane_b_i,
    input  logic [W-1:0] lane_c_i,
    output logic [W-1:0] result_o,
    output logic         result_valid_o,
    output logic         busy_o,
    output logic         div_zero_o
);
    import fuse_pkg::*;

    localparam int NW = 2 * W + 1;

    typedef struct packed {
        fuse_state_t  st;
        logic [2:0]   op;
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
        logic [W-1:0] res;
        logic         vld;
        logic         dz;
        logic         neg;
        logic         zden;
    } ctl_t;

    ctl_t q, d;

    logic [2:0]    x_op;
    logic [W-1:0]  x_s1, x_s2, x_s3, x_s4, x_s5;
    logic [W-1:0]  x_res;
    logic [NW-1:0] x_num;
    logic          div_start;
    logic [NW-1:0] div_num_mag;
    logic [W-1:0]  div_den_mag;
    logic [NW-1:0] div_quo;
    logic [NW-1:0] quo_signed;
    logic          div_active;
    logic          div_done;
    logic          op_known;
    logic          op_five;

    fuse_expr #(.W(W), .NW(NW)) u_expr (
        .op_i (x_op),
        .s1_i (x_s1),
        .s2_i (x_s2),
        .s3_i (x_s3),
        .s4_i (x_s4),
        .s5_i (x_s5),
        .res_o(x_res),
        .num_o(x_num)
    );

    fuse_divider #(.NW(NW), .DW(W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (div_start),
        .num_i   (div_num_mag),
        .den_i   (div_den_mag),
        .quo_o   (div_quo),
        .active_o(div_active),
        .done_o  (div_done)
    );

    always_comb begin
        op_known = (opcode_i >= OPC_POLY) && (opcode_i <= OPC_DIFF2);
        op_five  = op_known && (opcode_i != OPC_MAC);

        // operand routing into the shared expression datapath
        if (q.st == ST_IDLE) begin
            x_op = opcode_i;
            x_s1 = lane_a_i;
            x_s2 = lane_b_i;
            x_s3 = lane_c_i;
            x_s4 = '0;
            x_s5 = '0;
        end else begin
            x_op = q.op;
            x_s1 = q.s1;
            x_s2 = q.s2;
            x_s3 = q.s3;
            x_s4 = lane_a_i;
            x_s5 = lane_b_i;
        end

        div_num_mag = x_num[NW-1] ? (~x_num + 1'b1) : x_num;
        div_den_mag = lane_b_i[W-1] ? (~lane_b_i + 1'b1) : lane_b_i;
        quo_signed  = q.neg ? (~div_quo + 1'b1) : div_quo;

        d         = q;
        d.vld     = 1'b0;
        d.dz      = 1'b0;
        div_start = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (issue_i && op_known) begin
                    d.op = opcode_i;
                    d.s1 = lane_a_i;
                    d.s2 = lane_b_i;
                    d.s3 = lane_c_i;
                    if (op_five) begin
                        d.st = ST_GATHER;
                    end else begin
                        d.res = x_res;
                        d.vld = 1'b1;
                    end
                end
            end
            ST_GATHER: begin
                if (q.op == OPC_QUOT) begin
                    div_start = 1'b1;
                    d.neg     = x_num[NW-1] ^ lane_b_i[W-1];
                    d.zden    = (lane_b_i == '0);
                    d.st      = ST_DIVIDE;
                end else begin
                    d.res = x_res;
                    d.vld = 1'b1;
                    d.st  = ST_IDLE;
                end
            end
            ST_DIVIDE: begin
                if (div_done) begin
                    d.res = q.zden ? '1 : quo_signed[W-1:0];
                    d.dz  = q.zden;
                    d.vld = 1'b1;
                    d.st  = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign result_o       = q.res;
    assign result_valid_o = q.vld;
    assign busy_o         = (q.st != ST_IDLE);
    assign div_zero_o     = q.dz;

    // R2: single multiply-add answers in the next cycle
    assert_mac_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && !busy_o && opcode_i == OPC_MAC) |=> result_valid_o);

    // R6: five-source issue occupies the unit for its second operand cycle
    assert_five_src_gather_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && !busy_o && opcode_i >= OPC_POLY && opcode_i <= OPC_DIFF2
         && opcode_i != OPC_MAC) |=> (busy_o && !result_valid_o));

    // R7: a result is only presented once the unit is free again
    assert_valid_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid_o |-> !busy_o);

    // R8: zero-divisor flag accompanies an all-ones result
    assert_dz_all_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero_o |-> (result_valid_o && (&result_o)));

    // R10: the divider only runs while the unit reports busy
    assert_busy_covers_div_R10: assert property (@(posedge clk) disable iff (!rst_n)
        div_active |-> busy_o);

endmodule

// File: tb/sim_fused_op_unit.sv
module sim_fused_op_unit;

    localparam int W = 16;
    localparam int DIV_LAT = 2 * W + 4;

    logic         clk;
    logic         rst_n;
    logic         issue_i;
    logic [2:0]   opcode_i;
    logic [W-1:0] lane_a_i, lane_b_i, lane_c_i;
    logic [W-1:0] result_o;
    logic         result_valid_o;
    logic         busy_o;
    logic         div_zero_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    fused_op_unit #(.W(W)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .issue_i       (issue_i),
        .opcode_i      (opcode_i),
        .lane_a_i      (lane_a_i),
        .lane_b_i      (lane_b_i),
        .lane_c_i      (lane_c_i),
        .result_o      (result_o),
        .result_valid_o(result_valid_o),
        .busy_o        (busy_o),
        .div_zero_o    (div_zero_o)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint sx(input logic [W-1:0] v);
        return longint'($signed(v));
    endfunction

    // reference model built from R1..R5, R8, R9
    function automatic logic [W-1:0] model(input logic [2:0] op,
            input logic [W-1:0] a, b, c, dd, e, output bit dz);
        longint s1, s2, s3, s4, s5, r;
        s1 = sx(a); s2 = sx(b); s3 = sx(c); s4 = sx(dd); s5 = sx(e);
        dz = 0;
        case (op)
            3'd1: r = s1 + s2 * (s3 + s4 + s5 * s2);
            3'd2: r = s1 + s2 * s3;
            3'd3: begin
                if (s5 == 0) begin dz = 1; r = -1; end
                else r = (s3 * s4 - s1 * s2) / s5;
            end
            3'd4: r = s1 + s2 * s3 + s4 * s5;
            default: r = s1 - s2 * s3 - s4 * s5;
        endcase
        return r[W-1:0];
    endfunction

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd1: return "R1";
            3'd2: return "R2";
            3'd3: return "R3";
            3'd4: return "R4";
            default: return "R5";
        endcase
    endfunction

    // issue one operation; when intrude is set, try a second issue while busy (R10)
    task automatic run_op(input logic [2:0] op, input logic [W-1:0] a, b, c, dd, e,
                          input bit intrude);
        logic [W-1:0] exp;
        bit dz;
        int k;
        int exp_lat;
        exp = model(op, a, b, c, dd, e, dz);
        exp_lat = (op == 3'd2) ? 1 : ((op == 3'd3) ? DIV_LAT : 2);
        @(negedge clk);
        issue_i = 1'b1; opcode_i = op;
        lane_a_i = a; lane_b_i = b; lane_c_i = c;
        @(negedge clk);
        k = 1;
        if (intrude) begin
            issue_i = 1'b1; opcode_i = 3'd2;
        end else begin
            issue_i = 1'b0;
        end
        lane_a_i = dd; lane_b_i = e; lane_c_i = 16'h0101;
        if (op != 3'd2) check(busy_o == 1'b1, "R6 busy in operand cycle", busy_o, 1);
        while (!result_valid_o && k < DIV_LAT + 10) begin
            @(negedge clk);
            k++;
            lane_a_i = 16'h7777; lane_b_i = 16'h0003; lane_c_i = 16'h0005;
            if (!result_valid_o && op == 3'd3)
                check(busy_o == 1'b1, "R7 busy during divide", busy_o, 1);
        end
        issue_i = 1'b0;
        check(k == exp_lat, op == 3'd2 ? "R2 latency" : (op == 3'd3 ? "R7 latency" : "R6 latency"),
              k, exp_lat);
        check(result_o == exp, tag_of(op), sx(result_o), sx(exp));
        check(div_zero_o == dz, "R8 zero flag", div_zero_o, dz);
        check(busy_o == 1'b0, "R7 idle at result", busy_o, 0);
        @(negedge clk);
        check(div_zero_o == 1'b0, "R8 flag one cycle", div_zero_o, 0);
        if (intrude)
            check(result_valid_o == 1'b0, "R10 intruder gave no result", result_valid_o, 0);
    endtask

    task automatic test_reset;
        check(result_o == '0, "R12 result", result_o, 0);
        check(result_valid_o == 1'b0, "R12 valid", result_valid_o, 0);
        check(busy_o == 1'b0, "R12 busy", busy_o, 0);
        check(div_zero_o == 1'b0, "R12 dz", div_zero_o, 0);
    endtask

    task automatic test_poly;
        run_op(3'd1, 16'd3, 16'd4, 16'd5, 16'd6, 16'd7, 0);
        run_op(3'd1, -16'sd9, 16'd300, -16'sd2, 16'd11, -16'sd5, 0);
    endtask

    task automatic test_mac;
        run_op(3'd2, 16'd10, 16'd20, 16'd30, 16'd0, 16'd0, 0);
        run_op(3'd2, 16'd1, 16'd300, 16'd300, 16'd0, 16'd0, 0);   // R9 wrap
        run_op(3'd2, -16'sd5, -16'sd7, 16'd9, 16'd0, 16'd0, 0);
    endtask

    task automatic test_quot;
        run_op(3'd3, 16'd2, 16'd3, 16'd10, 16'd5, 16'd4, 0);      // 44/4
        run_op(3'd3, 16'd1, 16'd7, 16'd0, 16'd0, 16'd2, 0);       // -7/2 -> -3
        run_op(3'd3, 16'd0, 16'd0, 16'd7, 16'd1, -16'sd2, 0);     // 7/-2 -> -3
        run_op(3'd3, 16'd3, 16'd5, 16'd1, 16'd1, -16'sd4, 0);     // -14/-4 -> 3
        run_op(3'd3, 16'h8000, 16'h8000, 16'h7fff, 16'h7fff, 16'd3, 0); // R9 extreme
        run_op(3'd3, 16'd0, 16'd0, 16'd100, 16'd100, 16'h8000, 0);
    endtask

    task automatic test_zero_div;
        run_op(3'd3, 16'd4, 16'd5, 16'd6, 16'd7, 16'd0, 0);
    endtask

    task automatic test_sum_diff;
        run_op(3'd4, 16'd1, 16'd2, 16'd3, 16'd4, 16'd5, 0);
        run_op(3'd4, -16'sd100, 16'd250, 16'd250, -16'sd3, 16'd999, 0);
        run_op(3'd5, 16'd100, 16'd2, 16'd3, 16'd4, 16'd5, 0);
        run_op(3'd5, 16'h8000, -16'sd1, 16'd1, 16'h7fff, 16'd2, 0);
    endtask

    task automatic test_busy_ignore;
        run_op(3'd3, 16'd6, 16'd1, 16'd20, 16'd3, 16'd5, 1);      // R10 during divide
        run_op(3'd4, 16'd2, 16'd3, 16'd4, 16'd5, 16'd6, 1);       // R10 in operand cycle
    endtask

    task automatic test_bad_opcode;
        logic [W-1:0] held;
        held = result_o;
        for (int op = 0; op < 8; op++) begin
            if (op >= 1 && op <= 5) continue;
            @(negedge clk);
            issue_i = 1'b1; opcode_i = 3'(op);
            lane_a_i = 16'd9; lane_b_i = 16'd9; lane_c_i = 16'd9;
            @(negedge clk);
            issue_i = 1'b0;
            for (int i = 0; i < 4; i++) begin
                check(result_valid_o == 1'b0, "R11 no result", result_valid_o, 0);
                check(busy_o == 1'b0, "R11 not busy", busy_o, 0);
                @(negedge clk);
            end
            check(result_o == held, "R11 result held", result_o, held);
        end
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; issue_i = 1'b0; opcode_i = '0;
        lane_a_i = '0; lane_b_i = '0; lane_c_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_poly();
        test_mac();
        test_quot();
        test_zero_div();
        test_sum_diff();
        test_busy_ignore();
        test_bad_opcode();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule